// File: doc/BRIEF.md
# Extended Capability Chain Walker

This engine searches the linked list of extended capability headers that sits in the upper part of a 4 KB configuration space, and appends new entries to that list. It reaches the space one 32-bit dword at a time through a synchronous memory port with a read latency of one cycle. Every header carries a 16-bit capability identifier in bits 15:0, a 4-bit version in bits 19:16 and a 12-bit byte offset to the next header in bits 31:20. A next offset of zero ends the list, and an all-zero dword at the list head (0x100) means the list is empty.

A find command returns the byte offset of the first header whose identifier matches, together with the offset of the header visited just before it. The search identifier is 17 bits wide. Any value above 0xFFFF never matches, so a find with such a value walks to the end of the list and reports the tail as the previous offset. An append command either places the first header at 0x100, or walks to the tail, rewrites the tail's next field to point at the new offset and then writes the new header with a next field of zero.

The controller has six states. ST_IDLE waits for a command. ST_READ issues a header read. ST_EVAL decodes the returned header. ST_LINK rewrites the tail header. ST_PLACE writes the new header. ST_DONE pulses the result. The transitions are as follows. ST_IDLE goes to ST_READ when a walk is needed, to ST_PLACE when the append targets 0x100, and to ST_DONE when an append is rejected. ST_READ goes to ST_EVAL. ST_EVAL goes back to ST_READ to follow a next pointer, to ST_LINK when an append reaches the tail, and to ST_DONE on a match, an empty list, the end of a find, a bad offset or the step limit. ST_LINK goes to ST_PLACE. ST_PLACE goes to ST_DONE. ST_DONE goes to ST_IDLE.

Top module: `capwalk_engine`

## Requirements
- R1: Each header is decoded and written as identifier in bits 15:0, version in bits 19:16 and next byte offset in bits 31:20; an appended header has a next field of 0.
- R2: A find starts at byte offset 0x100 and returns the offset of the first header whose identifier equals cmd_id, with res_prev set to the header visited before it (0 when the match is at 0x100) and err low.
- R3: If the dword at 0x100 is zero, a find returns res_off 0, res_prev 0 and err low, and an append to any offset other than 0x100 is rejected with err high, res_off 0 and res_prev 0, with no memory write.
- R4: A search identifier above 0xFFFF (cmd_id bit 16 set) never matches. A find that reaches a next field of 0 without a match returns res_off 0 and res_prev equal to the last visited offset, with err low.
- R5: Every offset reached through a next pointer must be a multiple of 4 from 0x100 to 0xFF8. Otherwise the command ends with err high, res_off 0 and res_prev 0, and no read goes outside that range.
- R6: An append at 0x100 performs no walk and exactly one write: dword 0x100 receives {12'h000, cmd_ver, cmd_id[15:0]}. The result is res_off 0x100, res_prev 0.
- R7: An append at another offset walks to the tail. It rewrites the tail's bits 31:20 with the new offset and keeps the tail's bits 19:0. It then writes the new header, and returns res_off equal to the new offset and res_prev equal to the tail offset.
- R8: An append is rejected before any memory access, with err high and no write, when cmd_size is below 8, cmd_off + cmd_size exceeds 0x1000, cmd_off is below 0x100, or cmd_off is not a multiple of 4. An append at 0xFF8 of size 8 is accepted.
- R9: A walk that would need to read more than 1024 headers ends with err high, after exactly 1024 header reads.
- R10: A command is taken only in ST_IDLE while cmd_valid is high. busy is high from the next cycle until the result. done is high for exactly one cycle, together with err, res_off and res_prev. Read data is used in the cycle after the read request.
- R11: After reset the engine is in ST_IDLE with busy, done, mem_rd_en and mem_wr_en low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, sampled in idle |
| cmd_append | input | 1 | 1 = append, 0 = find |
| cmd_id | input | 17 | Search or new capability identifier (bit 16 only meaningful for find) |
| cmd_ver | input | 4 | Version of the appended header |
| cmd_off | input | 12 | Byte offset of the appended header |
| cmd_size | input | 13 | Byte size of the appended capability |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle result strobe |
| err | output | 1 | Command failed (valid with done) |
| res_off | output | 12 | Found or appended offset |
| res_prev | output | 12 | Previous header offset |
| mem_rd_en | output | 1 | Read request |
| mem_wr_en | output | 1 | Write request |
| mem_addr | output | 10 | Dword index into the space |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after mem_rd_en |

## Verification
The assertions assume that the memory returns the requested dword exactly one cycle after mem_rd_en, and that no other agent writes the space while a command is in flight. The bench models the memory as a registered array that updates only on the engine's own writes. It preloads list contents only while the engine is idle. It drives commands as single-cycle pulses at the falling edge, so every header the engine reads is stable for the whole walk.

// File: rtl/capwalk_pkg.sv
package capwalk_pkg;

    localparam int HDR_ID_W   = 16;
    localparam int HDR_VER_W  = 4;
    localparam int HDR_NEXT_W = 12;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_EVAL,
        ST_LINK,
        ST_PLACE,
        ST_DONE
    } walk_state_e;

    typedef struct packed {
        logic [HDR_NEXT_W-1:0] next;
        logic [HDR_VER_W-1:0]  ver;
        logic [HDR_ID_W-1:0]   id;
    } cap_hdr_t;

endpackage

// File: rtl/capwalk_bounds.sv
module capwalk_bounds #(
    parameter int OFF_W       = 12,
    parameter int BASE_OFF    = 256,
    parameter int SPACE_BYTES = 4096,
    parameter int MIN_SIZE    = 8
) (
    input  logic [OFF_W-1:0] walk_off,
    input  logic [OFF_W-1:0] place_off,
    input  logic [OFF_W:0]   place_size,
    output logic             walk_ok,
    output logic             place_ok
);
    localparam int SUM_W = OFF_W + 2;
    localparam logic [OFF_W-1:0] LO_L  = OFF_W'(BASE_OFF);
    localparam logic [OFF_W-1:0] HI_L  = OFF_W'(SPACE_BYTES - 8);
    localparam logic [SUM_W-1:0] END_L = SUM_W'(SPACE_BYTES);
    localparam logic [OFF_W:0]   MIN_L = (OFF_W+1)'(MIN_SIZE);

    logic [SUM_W-1:0] end_sum;

    always_comb begin
        end_sum  = SUM_W'(place_off) + SUM_W'(place_size);
        walk_ok  = (walk_off >= LO_L) && (walk_off <= HI_L) && (walk_off[1:0] == 2'b00);
        place_ok = (place_off >= LO_L) && (place_off[1:0] == 2'b00) &&
                   (place_size >= MIN_L) && (end_sum <= END_L);
    end
endmodule

// File: rtl/capwalk_steps.sv
module capwalk_steps #(
    parameter int MAX_STEPS = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam int CNT_W = $clog2(MAX_STEPS + 1);
    localparam logic [CNT_W-1:0] MAX_L  = CNT_W'(MAX_STEPS);
    localparam logic [CNT_W-1:0] LAST_L = CNT_W'(MAX_STEPS - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc && (cnt_q != MAX_L)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last = (cnt_q == LAST_L);

    // R9
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= MAX_L);

    // R9
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0));
endmodule

// File: rtl/capwalk_engine.sv
module capwalk_engine #(
    parameter int OFF_W       = 12,
    parameter int BASE_OFF    = 256,
    parameter int SPACE_BYTES = 4096,
    parameter int MIN_SIZE    = 8,
    parameter int MAX_STEPS   = 1024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic             cmd_append,
    input  logic [16:0]      cmd_id,
    input  logic [3:0]       cmd_ver,
    input  logic [OFF_W-1:0] cmd_off,
    input  logic [OFF_W:0]   cmd_size,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic [OFF_W-1:0] res_off,
    output logic [OFF_W-1:0] res_prev,
    output logic             mem_rd_en,
    output logic             mem_wr_en,
    output logic [OFF_W-3:0] mem_addr,
    output logic [31:0]      mem_wdata,
    input  logic [31:0]      mem_rdata
);
    import capwalk_pkg::*;

    localparam int ADDR_W = OFF_W - 2;
    localparam logic [OFF_W-1:0]  BASE_L   = OFF_W'(BASE_OFF);
    localparam logic [ADDR_W-1:0] LO_IDX_L = ADDR_W'(BASE_OFF / 4);
    localparam logic [ADDR_W-1:0] HI_IDX_L = ADDR_W'((SPACE_BYTES - 8) / 4);

    walk_state_e state_q, state_d;

    logic             app_q;
    logic [16:0]      id_q;
    logic [3:0]       ver_q;
    logic [OFF_W-1:0] off_q, cur_q, prev_q, tail_q;
    logic [19:0]      tail_low_q;
    logic             first_q;
    logic             err_q;
    logic [OFF_W-1:0] roff_q, rprev_q;

    cap_hdr_t hdr;
    logic     walk_ok, place_ok, step_last;
    logic     is_empty, is_match, is_tail;

    assign hdr = cap_hdr_t'(mem_rdata);

    capwalk_bounds #(
        .OFF_W(OFF_W), .BASE_OFF(BASE_OFF),
        .SPACE_BYTES(SPACE_BYTES), .MIN_SIZE(MIN_SIZE)
    ) bounds_i (
        .walk_off  (hdr.next),
        .place_off (cmd_off),
        .place_size(cmd_size),
        .walk_ok   (walk_ok),
        .place_ok  (place_ok)
    );

    capwalk_steps #(.MAX_STEPS(MAX_STEPS)) steps_i (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (state_q == ST_IDLE),
        .inc  (state_q == ST_EVAL),
        .last (step_last)
    );

    always_comb begin
        is_empty = first_q && (mem_rdata == '0);
        is_match = !app_q && !id_q[16] && (hdr.id == id_q[15:0]);
        is_tail  = (hdr.next == '0);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_valid) begin
                    if (cmd_append && !place_ok)        state_d = ST_DONE;
                    else if (cmd_append && cmd_off == BASE_L) state_d = ST_PLACE;
                    else                                state_d = ST_READ;
                end
            end
            ST_READ:  state_d = ST_EVAL;
            ST_EVAL: begin
                if (is_empty || is_match)            state_d = ST_DONE;
                else if (is_tail)                    state_d = app_q ? ST_LINK : ST_DONE;
                else if (!walk_ok || step_last)      state_d = ST_DONE;
                else                                 state_d = ST_READ;
            end
            ST_LINK:  state_d = ST_PLACE;
            ST_PLACE: state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // walk datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            app_q <= 1'b0; id_q <= '0; ver_q <= '0; off_q <= '0;
            cur_q <= '0; prev_q <= '0; tail_q <= '0; tail_low_q <= '0;
            first_q <= 1'b0; err_q <= 1'b0; roff_q <= '0; rprev_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        app_q   <= cmd_append;
                        id_q    <= cmd_id;
                        ver_q   <= cmd_ver;
                        off_q   <= cmd_off;
                        cur_q   <= BASE_L;
                        prev_q  <= '0;
                        tail_q  <= '0;
                        first_q <= 1'b1;
                        err_q   <= cmd_append && !place_ok;
                        roff_q  <= '0;
                        rprev_q <= '0;
                    end
                end
                ST_EVAL: begin
                    first_q <= 1'b0;
                    if (is_empty) begin
                        err_q <= app_q;
                    end else if (is_match) begin
                        roff_q  <= cur_q;
                        rprev_q <= prev_q;
                    end else if (is_tail) begin
                        if (app_q) begin
                            tail_q     <= cur_q;
                            tail_low_q <= mem_rdata[19:0];
                        end else begin
                            rprev_q <= cur_q;
                        end
                    end else if (!walk_ok || step_last) begin
                        err_q <= 1'b1;
                    end else begin
                        prev_q <= cur_q;
                        cur_q  <= hdr.next;
                    end
                end
                ST_PLACE: begin
                    roff_q  <= off_q;
                    rprev_q <= tail_q;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy      = (state_q != ST_IDLE) && (state_q != ST_DONE);
        done      = (state_q == ST_DONE);
        mem_rd_en = (state_q == ST_READ);
        mem_wr_en = (state_q == ST_LINK) || (state_q == ST_PLACE);
        mem_addr  = cur_q[OFF_W-1:2];
        mem_wdata = '0;
        unique case (state_q)
            ST_LINK: begin
                mem_addr  = tail_q[OFF_W-1:2];
                mem_wdata = {off_q, tail_low_q};
            end
            ST_PLACE: begin
                mem_addr  = off_q[OFF_W-1:2];
                mem_wdata = {12'h000, ver_q, id_q[15:0]};
            end
            default: ;
        endcase
    end

    assign err      = err_q;
    assign res_off  = roff_q;
    assign res_prev = rprev_q;

    // R10
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && !done) |=> (busy || done));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5
    rd_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> (mem_addr >= LO_IDX_L && mem_addr <= HI_IDX_L));

    // R7
    link_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_en && !$past(mem_wr_en) && app_q && off_q != BASE_L)
        |=> (mem_wr_en && mem_addr == off_q[OFF_W-1:2]));

    // R8
    reject_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err_q && app_q) |-> $past(!mem_wr_en));
endmodule

// File: tb/capwalk_engine_tb.sv
`timescale 1ns/1ps
module capwalk_engine_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0, cmd_append = 1'b0;
    logic [16:0] cmd_id = '0;
    logic [3:0]  cmd_ver = '0;
    logic [11:0] cmd_off = '0;
    logic [12:0] cmd_size = '0;
    logic        busy, done, err, mem_rd_en, mem_wr_en;
    logic [11:0] res_off, res_prev;
    logic [9:0]  mem_addr;
    logic [31:0] mem_wdata, mem_rdata;

    always #10 clk = ~clk;

    capwalk_engine dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_append(cmd_append),
        .cmd_id(cmd_id), .cmd_ver(cmd_ver), .cmd_off(cmd_off), .cmd_size(cmd_size),
        .busy(busy), .done(done), .err(err), .res_off(res_off), .res_prev(res_prev),
        .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    logic [31:0] mem [1024];
    int          wr_cnt = 0;

    always @(posedge clk) begin
        if (mem_wr_en) begin
            mem[mem_addr] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
        end
        if (mem_rd_en) mem_rdata <= mem[mem_addr];
    end

    int n_chk = 0, n_bad = 0;
    logic        g_err, g_busy, g_done_after;
    logic [11:0] g_off, g_prev;
    int          g_cyc, g_wr;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 1024; i++) mem[i] = '0;
    endtask

    task automatic put_hdr(input logic [11:0] off, input logic [15:0] id,
                           input logic [3:0] ver, input logic [11:0] nxt);
        mem[off[11:2]] = {nxt, ver, id};
    endtask

    task automatic run_cmd(input logic app, input logic [16:0] id, input logic [3:0] ver,
                           input logic [11:0] off, input logic [12:0] size);
        int w0;
        w0 = wr_cnt;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_append = app; cmd_id = id;
        cmd_ver = ver; cmd_off = off; cmd_size = size;
        @(negedge clk);
        cmd_valid = 1'b0;
        g_busy = busy;
        g_cyc = 1;
        while (!done && g_cyc < 5000) begin
            @(negedge clk);
            g_cyc++;
        end
        g_err = err; g_off = res_off; g_prev = res_prev;
        @(negedge clk);
        g_done_after = done;
        g_wr = wr_cnt - w0;
    endtask

    typedef struct packed {
        logic [16:0] id;
        logic [11:0] off;
        logic [11:0] prev;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{17'h00001, 12'h100, 12'h000},
        '{17'h0000E, 12'h140, 12'h100},
        '{17'h00003, 12'h200, 12'h140},
        '{17'h00007, 12'h000, 12'h200},
        '{17'h1FFFF, 12'h000, 12'h200},
        '{17'h10001, 12'h000, 12'h200}
    };

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R10 watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        clear_mem();
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 busy", busy, 0);
        chk("R11 done", done, 0);
        chk("R11 rd", mem_rd_en, 0);
        chk("R11 wr", mem_wr_en, 0);
        rst_n = 1'b1;

        // R2 / R4 vector table
        put_hdr(12'h100, 16'h0001, 4'h1, 12'h140);
        put_hdr(12'h140, 16'h000E, 4'h2, 12'h200);
        put_hdr(12'h200, 16'h0003, 4'h1, 12'h000);
        for (int v = 0; v < 6; v++) begin
            run_cmd(1'b0, VECS[v].id, 4'h0, 12'h0, 13'h0);
            chk($sformatf("R2/R4 vec%0d off", v), g_off, VECS[v].off);
            chk($sformatf("R2/R4 vec%0d prev", v), g_prev, VECS[v].prev);
            chk($sformatf("R2/R4 vec%0d err", v), g_err, 0);
        end

        // R3 empty list
        clear_mem();
        run_cmd(1'b0, 17'h00001, 4'h0, 12'h0, 13'h0);
        chk("R3 empty off", g_off, 0);
        chk("R3 empty prev", g_prev, 0);
        chk("R3 empty err", g_err, 0);
        run_cmd(1'b1, 17'h00005, 4'h1, 12'h180, 13'd16);
        chk("R3 append empty err", g_err, 1);
        chk("R3 append empty writes", g_wr, 0);

        // R6 first header
        run_cmd(1'b1, 17'h00023, 4'h2, 12'h100, 13'd16);
        chk("R6 err", g_err, 0);
        chk("R6 off", g_off, 12'h100);
        chk("R6 prev", g_prev, 0);
        chk("R6 writes", g_wr, 1);
        chk("R6 R1 header", mem[12'h100 >> 2], 32'h0002_0023);

        // R7 link at tail
        run_cmd(1'b1, 17'h0ABCD, 4'h1, 12'h180, 13'd32);
        chk("R7 err", g_err, 0);
        chk("R7 off", g_off, 12'h180);
        chk("R7 prev", g_prev, 12'h100);
        chk("R7 writes", g_wr, 2);
        chk("R7 tail rewritten", mem[12'h100 >> 2], 32'h1802_0023);
        chk("R7 R1 new header", mem[12'h180 >> 2], 32'h0001_ABCD);
        run_cmd(1'b0, 17'h0ABCD, 4'h0, 12'h0, 13'h0);
        chk("R2 find appended off", g_off, 12'h180);
        chk("R2 find appended prev", g_prev, 12'h100);

        // R8 rejections
        run_cmd(1'b1, 17'h00009, 4'h1, 12'h300, 13'd4);
        chk("R8 small size err", g_err, 1);
        chk("R8 small size writes", g_wr, 0);
        run_cmd(1'b1, 17'h00009, 4'h1, 12'hFF8, 13'd16);
        chk("R8 past end err", g_err, 1);
        chk("R8 past end writes", g_wr, 0);
        run_cmd(1'b1, 17'h00009, 4'h1, 12'h302, 13'd8);
        chk("R8 misaligned err", g_err, 1);
        run_cmd(1'b1, 17'h00009, 4'h1, 12'h0FC, 13'd8);
        chk("R8 below base err", g_err, 1);
        chk("R8 below base writes", g_wr, 0);
        run_cmd(1'b1, 17'h00009, 4'h3, 12'hFF8, 13'd8);
        chk("R8 boundary err", g_err, 0);
        chk("R8 boundary prev", g_prev, 12'h180);
        chk("R8 boundary header", mem[12'hFF8 >> 2], 32'h0003_0009);

        // R5 bad next pointers
        clear_mem();
        put_hdr(12'h100, 16'h0001, 4'h1, 12'h102);
        run_cmd(1'b0, 17'h00005, 4'h0, 12'h0, 13'h0);
        chk("R5 misaligned err", g_err, 1);
        chk("R5 misaligned off", g_off, 0);
        put_hdr(12'h100, 16'h0001, 4'h1, 12'h080);
        run_cmd(1'b0, 17'h00005, 4'h0, 12'h0, 13'h0);
        chk("R5 low next err", g_err, 1);
        put_hdr(12'h100, 16'h0001, 4'h1, 12'hFFC);
        run_cmd(1'b0, 17'h00005, 4'h0, 12'h0, 13'h0);
        chk("R5 high next err", g_err, 1);
        chk("R5 high next prev", g_prev, 0);

        // R9 / R10 cyclic list
        put_hdr(12'h100, 16'h0001, 4'h1, 12'h100);
        run_cmd(1'b0, 17'h00005, 4'h0, 12'h0, 13'h0);
        chk("R10 busy during walk", g_busy, 1);
        chk("R9 cycle err", g_err, 1);
        chk("R9 step count", (g_cyc >= 2048 && g_cyc < 2060) ? 1 : 0, 1);
        chk("R10 done one cycle", g_done_after, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule